// File: doc/BRIEF.md
# Serial Break Transmission Controller

This block sits between a serial transmitter's shift logic and the output pin. On command it produces a break, which is a line held low for longer than any character. A start request is not acted on at once. It is held until the transmit holding register and the transmit shift register have both drained. The line is then forced low. A stop request ends the break only after the line has been low for at least one character time. If the stop arrives earlier, it is remembered and takes effect once that minimum is reached. A fixed guard period of high line, counted in bit periods, follows every break.

The host transmitter supplies a one-cycle bit-period tick, the character length in bit periods and the two empty flags. It combines `ovr_en` and `ovr_level` into the pin value. It also stops loading new characters while `tx_block` is high. A transmitter reset pulse cancels everything and returns the line to idle.

Top module: `serial_break_ctl`

## Requirements
- R1: After a one-cycle `brk_start` in idle, the break begins on the first clock edge at which `thr_empty` and `tsr_empty` are both high, and not before. With both already high, `brk_active` is high two cycles after the pulse. During the break `ovr_en`=1 and `ovr_level`=0.
- R2: `brk_start` is ignored while a start is pending, during a break and during the guard period. No second break follows.
- R3: A break lasts at least `char_len` bit ticks. A `brk_stop` at or after that point ends the break on the next edge. An earlier `brk_stop` is remembered, and the break ends on the edge after the tick count reaches `char_len`. With `char_len`=0 the first stop ends it.
- R4: When a break ends, the guard period begins with `ovr_en`=1 and `ovr_level`=1. It lasts exactly GUARD_BITS (default 12) bit ticks, after which all outputs return low.
- R5: `brk_stop` while idle or while a start is pending has no effect, and is not remembered for a later break.
- R6: `tx_block` is high throughout the break and the guard period. It is low in idle and while a start waits for the registers to drain.
- R7: A one-cycle `tx_reset` returns the block to idle on the next edge, from any state. It discards a pending start and a pending stop.
- R8: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| brk_start | input | 1 | Break start request pulse |
| brk_stop | input | 1 | Break stop request pulse |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| char_len | input | LEN_W | Character length in bit periods (start, data, parity, stop) |
| tx_reset | input | 1 | Transmitter reset pulse |
| ovr_en | output | 1 | Line override active |
| ovr_level | output | 1 | Level driven while override active |
| brk_active | output | 1 | Line is being held low as a break |
| tx_block | output | 1 | Transmitter must not load new data |

## Verification
A stop request can arrive in the same cycle as the bit tick that completes the minimum break length. In that cycle the stored count is still one short, so the stop must be latched as pending rather than lost. The bench drives `brk_stop` and `bit_tick` together on the tick that reaches `char_len`. It expects the break to still be active after that edge and the guard period to begin on the following edge. A second overlap is a stop pulse in the same cycle as a `tx_reset`; the bench checks that the reset wins and that no stop carries into the next break.

// File: rtl/serial_break_ctl.sv
module serial_break_ctl #(
  parameter int LEN_W      = 4,
  parameter int GUARD_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             brk_start,
  input  logic             brk_stop,
  input  logic             thr_empty,
  input  logic             tsr_empty,
  input  logic [LEN_W-1:0] char_len,
  input  logic             tx_reset,
  output logic             ovr_en,
  output logic             ovr_level,
  output logic             brk_active,
  output logic             tx_block
);
  localparam int GW    = $clog2(GUARD_BITS + 1);
  localparam int CNT_W = ((LEN_W > GW) ? LEN_W : GW) + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BREAK, S_GUARD} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             stop_pend;

  wire min_met   = cnt >= CNT_W'(char_len);
  wire cnt_max   = &cnt;
  wire guard_end = bit_tick && (cnt == CNT_W'(GUARD_BITS - 1));
  wire end_break = min_met && (stop_pend || brk_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      stop_pend <= 1'b0;
    end else if (tx_reset) begin
      st        <= S_IDLE;
      cnt       <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (brk_start) st <= S_WAIT;
        S_WAIT:
          if (thr_empty && tsr_empty) begin
            st        <= S_BREAK;
            cnt       <= '0;
            stop_pend <= 1'b0;
          end
        S_BREAK:
          if (end_break) begin
            st        <= S_GUARD;
            cnt       <= '0;
            stop_pend <= 1'b0;
          end else begin
            if (brk_stop) stop_pend <= 1'b1;
            if (bit_tick && !cnt_max) cnt <= cnt + CNT_W'(1);
          end
        S_GUARD:
          if (guard_end) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else if (bit_tick) begin
            cnt <= cnt + CNT_W'(1);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign brk_active = (st == S_BREAK);
  assign ovr_level  = (st == S_GUARD);
  assign ovr_en     = brk_active || ovr_level;
  assign tx_block   = ovr_en;
endmodule

// File: rtl/break_ctl_chk.sv
module break_ctl_chk #(
  parameter int LEN_W      = 4,
  parameter int GUARD_BITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             thr_empty,
  input logic             tsr_empty,
  input logic [LEN_W-1:0] char_len,
  input logic             tx_reset,
  input logic             ovr_en,
  input logic             ovr_level,
  input logic             brk_active,
  input logic             tx_block
);
  localparam int CW = LEN_W + 6;

  logic [CW-1:0] brk_cnt, grd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_cnt <= '0;
      grd_cnt <= '0;
    end else begin
      if (!brk_active) brk_cnt <= '0;
      else if (bit_tick && !(&brk_cnt)) brk_cnt <= brk_cnt + CW'(1);
      if (!ovr_level) grd_cnt <= '0;
      else if (bit_tick && !(&grd_cnt)) grd_cnt <= grd_cnt + CW'(1);
    end
  end

  assert_start_after_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_active) |-> $past(thr_empty && tsr_empty));

  assert_min_break_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) && !$past(tx_reset) |-> brk_cnt >= CW'($past(char_len)));

  assert_guard_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) && !$past(tx_reset) |-> ovr_en && ovr_level);

  assert_guard_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_level) && !$past(tx_reset) |-> grd_cnt == CW'(GUARD_BITS));

  assert_block_during_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |-> tx_block);

  assert_reset_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> !ovr_en && !brk_active && !tx_block);
endmodule

bind serial_break_ctl break_ctl_chk #(.LEN_W(LEN_W), .GUARD_BITS(GUARD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .thr_empty(thr_empty),
  .tsr_empty(tsr_empty), .char_len(char_len), .tx_reset(tx_reset),
  .ovr_en(ovr_en), .ovr_level(ovr_level), .brk_active(brk_active), .tx_block(tx_block)
);

// File: tb/tb_serial_break_ctl.sv
module tb_serial_break_ctl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, bit_tick = 1'b0, brk_start = 1'b0, brk_stop = 1'b0;
  logic       thr_empty = 1'b1, tsr_empty = 1'b1, tx_reset = 1'b0;
  logic [3:0] char_len = 4'd0;
  logic       ovr_en, ovr_level, brk_active, tx_block;

  int checks = 0, fails = 0;

  serial_break_ctl dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .brk_start(brk_start),
    .brk_stop(brk_stop), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
    .char_len(char_len), .tx_reset(tx_reset), .ovr_en(ovr_en),
    .ovr_level(ovr_level), .brk_active(brk_active), .tx_block(tx_block)
  );

  // {char_len, stop issued after N ticks, expected ticks in break}
  localparam logic [13:0] VECS [8] = '{
    {4'd10, 5'd0,  5'd10}, {4'd10, 5'd3,  5'd10}, {4'd10, 5'd10, 5'd10},
    {4'd10, 5'd14, 5'd14}, {4'd7,  5'd2,  5'd7},  {4'd0,  5'd0,  5'd0},
    {4'd15, 5'd20, 5'd20}, {4'd1,  5'd1,  5'd1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    bit_tick = 1'b1; step(); bit_tick = 1'b0; step();
  endtask

  task automatic do_start();
    brk_start = 1'b1; step(); brk_start = 1'b0;
  endtask

  task automatic do_stop();
    brk_stop = 1'b1; step(); brk_stop = 1'b0;
  endtask

  task automatic do_reset();
    tx_reset = 1'b1; step(); tx_reset = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n, g, stop_at, exp_n;
    bit stopped;
    repeat (3) step();
    chk("R8 reset outputs", {28'd0, ovr_en, ovr_level, brk_active, tx_block}, 0);
    rst_n = 1'b1;
    step();
    chk("R8 idle after reset", {28'd0, ovr_en, ovr_level, brk_active, tx_block}, 0);

    for (int i = 0; i < 8; i++) begin
      char_len = VECS[i][13:10];
      stop_at  = int'(VECS[i][9:5]);
      exp_n    = int'(VECS[i][4:0]);
      do_start(); step();
      chk("R1 break drives low", {29'd0, ovr_en, ovr_level, brk_active}, 3'b101);
      n = 0; stopped = 1'b0;
      while (brk_active && n < 40) begin
        if (!stopped && n == stop_at) begin do_stop(); stopped = 1'b1; end
        else begin tick(); n++; end
      end
      chk("R3 break length in ticks", n, exp_n);
      chk("R4 R6 guard high and blocking", {29'd0, ovr_en, ovr_level, tx_block}, 3'b111);
      g = 0;
      while (ovr_en && g < 40) begin tick(); g++; end
      chk("R4 guard ticks", g, 12);
      chk("R6 idle releases transmitter", {30'd0, ovr_en, tx_block}, 0);
    end

    // R1 wait for drain, R5 stop while waiting, R2 start repeats
    char_len = 4'd0; thr_empty = 1'b0; tsr_empty = 1'b0;
    do_start(); repeat (3) step();
    chk("R1 waits for holding and shift registers", brk_active, 0);
    chk("R6 no block while draining", tx_block, 0);
    do_start();
    thr_empty = 1'b1; step();
    chk("R1 still waits for shift register", brk_active, 0);
    do_stop();
    chk("R5 stop while waiting", brk_active, 0);
    tsr_empty = 1'b1; step();
    chk("R1 break once drained", brk_active, 1);
    repeat (3) tick();
    chk("R5 stop while waiting not remembered", brk_active, 1);
    do_start();
    do_stop();
    chk("R3 stop with zero length", {30'd0, ovr_en, ovr_level}, 3);
    do_start();
    g = 0;
    while (ovr_en && g < 40) begin tick(); g++; end
    repeat (4) step();
    chk("R2 start in break or guard ignored", {30'd0, ovr_en, brk_active}, 0);

    // R5 stop while idle
    do_stop();
    do_start(); step();
    chk("R1 break starts", brk_active, 1);
    repeat (3) tick();
    chk("R5 idle stop not remembered", brk_active, 1);
    do_reset();
    chk("R7 reset from break", {29'd0, ovr_en, brk_active, tx_block}, 0);

    // R7 discards pending stop
    char_len = 4'd5;
    do_start(); step();
    tick(); tick(); do_stop();
    chk("R3 early stop keeps break", brk_active, 1);
    do_reset();
    chk("R7 reset with pending stop", brk_active, 0);
    do_start(); step();
    repeat (6) tick();
    chk("R7 pending stop discarded", brk_active, 1);
    tx_reset = 1'b1; brk_stop = 1'b1; step(); tx_reset = 1'b0; brk_stop = 1'b0;
    chk("R7 reset wins over stop", ovr_en, 0);
    do_start(); step();
    repeat (6) tick();
    chk("R7 stop with reset not carried", brk_active, 1);
    do_reset();

    // R7 in guard and while waiting
    char_len = 4'd0;
    do_start(); step(); do_stop();
    tick(); tick(); tick();
    chk("R4 guard in progress", ovr_level, 1);
    do_reset();
    chk("R7 reset from guard", {30'd0, ovr_en, ovr_level}, 0);
    thr_empty = 1'b0;
    do_start(); step(); do_reset();
    thr_empty = 1'b1; repeat (3) step();
    chk("R7 pending start discarded", brk_active, 0);

    // stop in the same cycle as the tick that reaches the minimum
    char_len = 4'd3;
    do_start(); step();
    tick(); tick();
    bit_tick = 1'b1; brk_stop = 1'b1; step(); bit_tick = 1'b0; brk_stop = 1'b0;
    chk("R3 stop on completing tick still in break", brk_active, 1);
    step();
    chk("R3 R4 guard one edge later", {29'd0, ovr_en, ovr_level, brk_active}, 3'b110);
    do_reset();

    summary();
    $finish;
  end
endmodule